// File: doc/BRIEF.md
# AT Command Line Receiver

This block sits between a host's asynchronous serial transmit line and a command interpreter. It recovers characters from the serial stream and waits for the two-character attention prefix. It then collects the characters that follow into a line store until a carriage return arrives. At that point it raises a one-cycle strobe together with the line length and an overflow flag. The interpreter then reads the stored characters through a registered read port. Several commands may share one line, because the block stores the body untouched.

The block also tracks whether the link is in command mode or data mode. A completed dial line that does not end in a semicolon moves the block into data mode, and a dial line that ends in a semicolon leaves it in command mode. In data mode no lines are assembled. The receiver watches for three plus signs that are isolated in time: quiet for a programmable guard interval before the first one, spaced closer than the guard from each other, and quiet again for the guard interval after the third one. Such a sequence returns the block to command mode.

Top module: `at_line_rx`

## Requirements
- R1: Each character is a frame that starts with a low start bit on an idle-high line, followed by eight data bits sent least significant bit first and one high stop bit. The line is sampled at 16 times the bit rate, at mid-bit.
- R2: A frame whose stop bit reads low is discarded, and `framing_err` pulses for one cycle.
- R3: `cfg_fmt` selects the frame format. The values 00 and 11 mean eight data bits with no parity, and the character is kept with all eight bits. The value 01 means seven data bits with odd parity and the value 10 means seven data bits with even parity. In both seven-bit formats the parity bit is bit 7, the accepted character has bit 7 cleared, and a character with a parity mismatch is discarded while `parity_err` pulses.
- R4: A line begins only after 'A' followed directly by 'T', in either letter case. Characters received before this prefix are ignored, and the prefix itself is neither stored nor counted.
- R5: A carriage return (0x0D) ends the line. `line_valid` then pulses for one cycle with `line_len` set to the number of stored characters, and the characters can be read at addresses 0 to `line_len`-1 with a one-cycle read latency.
- R6: At most 63 characters are stored per line, and later characters are dropped. `line_ovf` is 1 with `line_valid` exactly when at least one character was dropped.
- R7: If the first stored character of a completed line is 'D' or 'd' and the last stored character is not ';', `mode_cmd` falls to 0 in the cycle after `line_valid`. A dial line whose last stored character is ';' leaves `mode_cmd` at 1.
- R8: While `mode_cmd` is 0, no line is assembled and `line_valid` stays low.
- R9: In data mode, the block returns to command mode (`mode_cmd` = 1) when three '+' characters arrive under these conditions: no character arrived for at least `cfg_guard` cycles before the first one, each later '+' arrives less than `cfg_guard` cycles after the one before it, and no character arrives for `cfg_guard` cycles after the third one.
- R10: The escape is rejected, and `mode_cmd` stays 0, if any other character arrives within the guard interval before or after the three '+' characters, or if the gap between two of the '+' characters reaches the guard interval.
- R11: After reset, `mode_cmd` is 1 and `line_valid`, `framing_err` and `parity_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial character input from the host, idle high |
| cfg_fmt | input | 2 | Frame format: 00/11 eight bits, 01 seven bits odd parity, 10 seven bits even parity |
| cfg_guard | input | GUARD_W (16) | Escape guard interval in clock cycles |
| rd_addr | input | ADDR_W (6) | Line store read address |
| rd_data | output | 8 | Line store read data, one cycle after `rd_addr` |
| line_valid | output | 1 | One-cycle strobe: a line has ended |
| line_len | output | LEN_W (6) | Stored character count of the last line |
| line_ovf | output | 1 | The last line had characters dropped |
| mode_cmd | output | 1 | 1 in command mode, 0 in data mode |
| framing_err | output | 1 | One-cycle pulse on a bad stop bit |
| parity_err | output | 1 | One-cycle pulse on a parity mismatch |

## Verification
Once the input is synchronized, the character strobe and the error pulses appear one cycle after the stop-bit mid-sample. That point falls about nine sample ticks before the frame ends. `line_valid` follows one cycle after the carriage return is accepted, and `mode_cmd` follows one cycle after that for a dial line. The bench drives each full frame, waits a few cycles past the end of the stop bit, and then compares event counters collected on falling edges, so every strobe has landed by then. The escape result falls exactly one guard interval after the third '+'. For that reason the bench samples `mode_cmd` once right after the third frame, while the guard has not yet run out, and once more after the guard has expired.

// File: rtl/atl_pkg.sv
package atl_pkg;
  localparam logic [7:0] CH_CR   = 8'h0D;
  localparam logic [7:0] CH_PLUS = 8'h2B;
  localparam logic [7:0] CH_SEMI = 8'h3B;

  localparam logic [1:0] FMT_7ODD  = 2'b01;
  localparam logic [1:0] FMT_7EVEN = 2'b10;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;
  typedef enum logic [1:0] {L_HUNT, L_GOT_A, L_BODY} ln_st_e;

  function automatic logic is_letter(input logic [7:0] c, input logic [7:0] upper);
    return (c == upper) || (c == (upper | 8'h20));
  endfunction
endpackage

// File: rtl/atl_uart_rx.sv
module atl_uart_rx
  import atl_pkg::*;
#(
  parameter int TICK_DIV = 27,
  parameter int OVS      = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxd,
  input  logic [1:0] fmt,
  output logic       ch_valid,
  output logic [7:0] ch_data,
  output logic       ferr,
  output logic       perr
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int OVS_W = $clog2(OVS);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
  localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS - 1);
  localparam logic [OVS_W-1:0] OVS_MID  = OVS_W'(OVS / 2 - 1);

  logic [DIV_W-1:0] div_cnt;
  logic             tick;
  logic [1:0]       sync;
  logic             rx_s;
  rx_st_e           state;
  logic [OVS_W-1:0] cnt;
  logic [2:0]       bit_idx;
  logic [7:0]       shreg;
  logic             seven;
  logic             par_bad;

  assign tick    = (div_cnt == DIV_LAST);
  assign rx_s    = sync[1];
  assign seven   = (fmt == FMT_7ODD) || (fmt == FMT_7EVEN);
  assign par_bad = ((fmt == FMT_7ODD) && !(^shreg)) || ((fmt == FMT_7EVEN) && (^shreg));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      sync    <= 2'b11;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      sync    <= {sync[0], rxd};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RX_IDLE;
      cnt      <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      ch_valid <= 1'b0;
      ch_data  <= '0;
      ferr     <= 1'b0;
      perr     <= 1'b0;
    end else begin
      ch_valid <= 1'b0;
      ferr     <= 1'b0;
      perr     <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: begin
            if (!rx_s) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (cnt == OVS_MID) begin
              cnt     <= '0;
              bit_idx <= '0;
              state   <= rx_s ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt == OVS_LAST) begin
              cnt   <= '0;
              shreg <= {rx_s, shreg[7:1]};
              if (bit_idx == 3'd7) state <= RX_STOP;
              else bit_idx <= bit_idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == OVS_LAST) begin
              cnt   <= '0;
              state <= RX_IDLE;
              if (!rx_s) begin
                ferr <= 1'b1;
              end else if (par_bad) begin
                perr <= 1'b1;
              end else begin
                ch_valid <= 1'b1;
                ch_data  <= seven ? {1'b0, shreg[6:0]} : shreg;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R2: a frame yields a character or one error, never both
  a_r2_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ch_valid, ferr, perr}));

  // R3: seven-bit formats deliver characters with bit 7 cleared
  a_r3_seven_bit_msb: assert property (@(posedge clk) disable iff (rst)
    (ch_valid && $stable(fmt) && seven) |-> (ch_data[7] == 1'b0));
endmodule

// File: rtl/atl_line.sv
module atl_line
  import atl_pkg::*;
#(
  parameter int MAX_LEN = 63,
  parameter int ADDR_W  = $clog2(MAX_LEN),
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ch_valid,
  input  logic [7:0]        ch_data,
  input  logic              cmd_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              line_valid,
  output logic [LEN_W-1:0]  line_len,
  output logic              line_ovf,
  output logic              to_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_LEN);

  logic [7:0]       store [0:DEPTH-1];
  ln_st_e           state;
  logic [LEN_W-1:0] len;
  logic             ovf;
  logic             first_d;
  logic             last_semi;
  logic             is_cr;
  logic             we;

  assign is_cr = (ch_data == CH_CR);
  assign we    = ch_valid && cmd_mode && (state == L_BODY) && !is_cr && (len < LEN_MAX);

  always_ff @(posedge clk) begin
    if (we) store[len[ADDR_W-1:0]] <= ch_data;
    rd_data <= store[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= L_HUNT;
      len        <= '0;
      ovf        <= 1'b0;
      first_d    <= 1'b0;
      last_semi  <= 1'b0;
      line_valid <= 1'b0;
      line_len   <= '0;
      line_ovf   <= 1'b0;
      to_data    <= 1'b0;
    end else begin
      line_valid <= 1'b0;
      to_data    <= 1'b0;
      if (!cmd_mode) begin
        state <= L_HUNT;
      end else if (ch_valid) begin
        case (state)
          L_HUNT: if (is_letter(ch_data, "A")) state <= L_GOT_A;
          L_GOT_A: begin
            if (is_letter(ch_data, "T")) begin
              state     <= L_BODY;
              len       <= '0;
              ovf       <= 1'b0;
              first_d   <= 1'b0;
              last_semi <= 1'b0;
            end else if (!is_letter(ch_data, "A")) begin
              state <= L_HUNT;
            end
          end
          L_BODY: begin
            if (is_cr) begin
              line_valid <= 1'b1;
              line_len   <= len;
              line_ovf   <= ovf;
              to_data    <= first_d && !last_semi;
              state      <= L_HUNT;
            end else if (len < LEN_MAX) begin
              len       <= len + 1'b1;
              last_semi <= (ch_data == CH_SEMI);
              if (len == '0) first_d <= is_letter(ch_data, "D");
            end else begin
              ovf <= 1'b1;
            end
          end
          default: state <= L_HUNT;
        endcase
      end
    end
  end

  // R6: reported length never exceeds the cap
  a_r6_len_cap: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> (line_len <= LEN_MAX));

  // R6: overflow is reported only for a full line
  a_r6_ovf_full: assert property (@(posedge clk) disable iff (rst)
    (line_valid && line_ovf) |-> (line_len == LEN_MAX));

  // R8: a line can only complete while in command mode
  a_r8_cmd_only: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> $past(cmd_mode));
endmodule

// File: rtl/atl_esc.sv
module atl_esc
  import atl_pkg::*;
#(
  parameter int GUARD_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ch_valid,
  input  logic [7:0]         ch_data,
  input  logic               ch_err,
  input  logic               to_data,
  input  logic [GUARD_W-1:0] guard,
  output logic               mode_cmd
);
  localparam logic [GUARD_W-1:0] IDLE_SAT = '1;

  logic [GUARD_W-1:0] idle_cnt;
  logic [1:0]         plus_cnt;
  logic               activity;
  logic               quiet;
  logic               esc_hit;

  assign activity = ch_valid || ch_err;
  assign quiet    = (idle_cnt >= guard);
  assign esc_hit  = !mode_cmd && (plus_cnt == 2'd3) && quiet && !activity;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_cmd <= 1'b1;
      idle_cnt <= '0;
      plus_cnt <= '0;
    end else begin
      if (activity) idle_cnt <= '0;
      else if (idle_cnt != IDLE_SAT) idle_cnt <= idle_cnt + 1'b1;

      if (esc_hit) mode_cmd <= 1'b1;
      else if (to_data) mode_cmd <= 1'b0;

      if (mode_cmd || esc_hit) begin
        plus_cnt <= '0;
      end else if (activity) begin
        if (ch_valid && (ch_data == CH_PLUS)) begin
          if (quiet) plus_cnt <= 2'd1;
          else if ((plus_cnt == 2'd1) || (plus_cnt == 2'd2)) plus_cnt <= plus_cnt + 1'b1;
          else plus_cnt <= '0;
        end else begin
          plus_cnt <= '0;
        end
      end
    end
  end

  // R9: command mode is re-entered only through a qualified escape
  a_r9_rise_by_escape: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_cmd) |-> $past(esc_hit));

  // R7: data mode is entered only after a completed dial line
  a_r7_fall_by_dial: assert property (@(posedge clk) disable iff (rst)
    $fell(mode_cmd) |-> $past(to_data));
endmodule

// File: rtl/at_line_rx.sv
module at_line_rx #(
  parameter int TICK_DIV = 27,
  parameter int MAX_LEN  = 63,
  parameter int GUARD_W  = 16,
  parameter int ADDR_W   = $clog2(MAX_LEN),
  parameter int LEN_W    = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rxd,
  input  logic [1:0]         cfg_fmt,
  input  logic [GUARD_W-1:0] cfg_guard,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [7:0]         rd_data,
  output logic               line_valid,
  output logic [LEN_W-1:0]   line_len,
  output logic               line_ovf,
  output logic               mode_cmd,
  output logic               framing_err,
  output logic               parity_err
);
  logic       ch_valid;
  logic [7:0] ch_data;
  logic       to_data;

  atl_uart_rx #(.TICK_DIV(TICK_DIV), .OVS(16)) u_rx (
    .clk(clk), .rst(rst), .rxd(rxd), .fmt(cfg_fmt),
    .ch_valid(ch_valid), .ch_data(ch_data), .ferr(framing_err), .perr(parity_err)
  );

  atl_line #(.MAX_LEN(MAX_LEN), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_line (
    .clk(clk), .rst(rst), .ch_valid(ch_valid), .ch_data(ch_data), .cmd_mode(mode_cmd),
    .rd_addr(rd_addr), .rd_data(rd_data), .line_valid(line_valid), .line_len(line_len),
    .line_ovf(line_ovf), .to_data(to_data)
  );

  atl_esc #(.GUARD_W(GUARD_W)) u_esc (
    .clk(clk), .rst(rst), .ch_valid(ch_valid), .ch_data(ch_data),
    .ch_err(framing_err || parity_err), .to_data(to_data), .guard(cfg_guard),
    .mode_cmd(mode_cmd)
  );
endmodule

// File: tb/at_line_rx_tb.sv
module at_line_rx_tb;
  localparam int DIV  = 1;
  localparam int BITC = 16 * DIV;
  localparam int GRD  = 400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rxd = 1'b1;
  logic [1:0]  cfg_fmt = 2'b00;
  logic [15:0] cfg_guard = 16'(GRD);
  logic [5:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        line_valid, line_ovf, mode_cmd, framing_err, parity_err;
  logic [5:0]  line_len;

  int n_chk = 0, n_bad = 0;
  int n_lv = 0, n_fe = 0, n_pe = 0, cap_len = 0, cap_ovf = 0;
  logic [7:0] exp_ch [0:79];

  always #5 clk = ~clk;

  at_line_rx #(.TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .rxd(rxd), .cfg_fmt(cfg_fmt), .cfg_guard(cfg_guard),
    .rd_addr(rd_addr), .rd_data(rd_data), .line_valid(line_valid), .line_len(line_len),
    .line_ovf(line_ovf), .mode_cmd(mode_cmd), .framing_err(framing_err),
    .parity_err(parity_err)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (line_valid) begin
        n_lv++;
        cap_len = int'(line_len);
        cap_ovf = int'(line_ovf);
      end
      if (framing_err) n_fe++;
      if (parity_err) n_pe++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic par_bit(input logic [7:0] c, input logic [1:0] f);
    return (f == 2'b01) ? ~(^c[6:0]) : (^c[6:0]);
  endfunction

  task automatic send_frame(input logic [7:0] b, input logic stop);
    @(negedge clk) rxd = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BITC) @(negedge clk);
    end
    rxd = stop;
    repeat (BITC) @(negedge clk);
    rxd = 1'b1;
    repeat (stop ? 4 : BITC) @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] c);
    if (cfg_fmt == 2'b01 || cfg_fmt == 2'b10) send_frame({par_bit(c, cfg_fmt), c[6:0]}, 1'b1);
    else send_frame(c, 1'b1);
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_char(s[i]);
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk) rd_addr = 6'(a);
    @(negedge clk) v = int'(rd_data);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pick();
    logic [7:0] c;
    do c = 8'($urandom_range(32, 126)); while (c == "D" || c == "d");
    return c;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v, base, blen, L;
    void'($urandom(32'h1c3d));
    repeat (6) @(negedge clk);
    rst = 1'b0;
    idle(4);
    // R11 reset state
    chk("R11 mode_cmd", int'(mode_cmd), 1);
    chk("R11 line_valid", int'(line_valid), 0);
    chk("R11 err", int'(framing_err | parity_err), 0);

    // R1 R4 R5 basic line
    base = n_lv;
    send_str("ATI1\r");
    chk("R5 strobe", n_lv - base, 1);
    chk("R5 len", cap_len, 2);
    rd(0, v); chk("R1 R4 char0", v, "I");
    rd(1, v); chk("R5 char1", v, "1");
    chk("R6 no ovf", cap_ovf, 0);

    // R4 leading junk and lowercase prefix
    base = n_lv;
    send_str("xyatZ\r");
    chk("R4 junk strobe", n_lv - base, 1);
    chk("R4 junk len", cap_len, 1);
    rd(0, v); chk("R4 junk char", v, "Z");
    base = n_lv;
    send_str("AxTQ\r");
    chk("R4 broken prefix ignored", n_lv - base, 0);
    base = n_lv;
    send_str("AT\r");
    chk("R4 empty line", n_lv - base, 1);
    chk("R4 empty len", cap_len, 0);

    // R6 overflow and exact fill
    send_str("AT");
    for (int i = 0; i < 70; i++) begin
      exp_ch[i] = 8'("E" + (i % 20));
      send_char(exp_ch[i]);
    end
    send_char(8'h0D);
    chk("R6 ovf len", cap_len, 63);
    chk("R6 ovf flag", cap_ovf, 1);
    rd(62, v); chk("R6 last kept", v, int'(exp_ch[62]));
    send_str("AT");
    for (int i = 0; i < 63; i++) send_char(8'("a" + (i % 26)));
    send_char(8'h0D);
    chk("R6 full len", cap_len, 63);
    chk("R6 full no ovf", cap_ovf, 0);

    // R2 framing error discards the character
    base = n_fe;
    send_str("AT");
    send_frame("Q", 1'b0);
    send_str("R\r");
    chk("R2 ferr pulse", n_fe - base, 1);
    chk("R2 len", cap_len, 1);
    rd(0, v); chk("R2 kept char", v, "R");

    // R3 parity formats and eight-bit pass-through
    cfg_fmt = 2'b01;
    base = n_pe;
    send_str("ATK");
    send_frame({~par_bit("M", 2'b01), 7'("M")}, 1'b1);
    send_str("N\r");
    chk("R3 odd perr", n_pe - base, 1);
    chk("R3 odd len", cap_len, 2);
    rd(1, v); chk("R3 odd char", v, "N");
    cfg_fmt = 2'b10;
    base = n_pe;
    send_str("ATW");
    send_frame({~par_bit("X", 2'b10), 7'("X")}, 1'b1);
    send_str("\r");
    chk("R3 even perr", n_pe - base, 1);
    chk("R3 even len", cap_len, 1);
    rd(0, v); chk("R3 even char", v, "W");
    cfg_fmt = 2'b00;
    send_str("AT");
    send_char(8'hC1);
    send_str("\r");
    rd(0, v); chk("R3 8bit char", v, 8'hC1);

    // R5 R6 random lines
    for (int n = 0; n < 7; n++) begin
      L = $urandom_range(0, 70);
      base = n_lv;
      send_str("AT");
      for (int i = 0; i < L; i++) begin
        exp_ch[i] = pick();
        send_char(exp_ch[i]);
      end
      send_char(8'h0D);
      blen = (L > 63) ? 63 : L;
      chk("R5 rand strobe", n_lv - base, 1);
      chk("R5 rand len", cap_len, blen);
      chk("R6 rand ovf", cap_ovf, (L > 63) ? 1 : 0);
      if (blen > 0) begin
        rd(0, v); chk("R5 rand first", v, int'(exp_ch[0]));
        rd(blen - 1, v); chk("R5 rand last", v, int'(exp_ch[blen - 1]));
      end
      chk("R7 rand stays cmd", int'(mode_cmd), 1);
    end

    // R7 dial handling
    send_str("ATDT55;\r");
    chk("R7 semicolon stays cmd", int'(mode_cmd), 1);
    send_str("atdt55\r");
    chk("R7 dial to data", int'(mode_cmd), 0);

    // R8 no lines in data mode
    base = n_lv;
    send_str("ATI\r");
    chk("R8 no strobe", n_lv - base, 0);

    // R9 valid escape
    idle(GRD + 50);
    send_str("+++");
    chk("R9 before guard", int'(mode_cmd), 0);
    idle(GRD + 50);
    chk("R9 escape", int'(mode_cmd), 1);

    // R10 rejected escapes
    send_str("ATD1\r");
    chk("R7 redial", int'(mode_cmd), 0);
    idle(GRD + 50);
    send_str("x+++");
    idle(GRD + 50);
    chk("R10 leading char", int'(mode_cmd), 0);
    idle(GRD + 50);
    send_str("+++y");
    idle(GRD + 50);
    chk("R10 trailing char", int'(mode_cmd), 0);
    idle(GRD + 50);
    send_str("+");
    idle(GRD + 50);
    send_str("++");
    idle(GRD + 50);
    chk("R10 wide gap", int'(mode_cmd), 0);
    send_str("+++");
    idle(GRD + 50);
    chk("R9 escape again", int'(mode_cmd), 1);

    base = n_lv;
    send_str("ATO\r");
    chk("R8 lines resume", n_lv - base, 1);
    rd(0, v); chk("R8 resume char", v, "O");

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule